// File: doc/BRIEF.md
# Microsequenced Fetch and Autoincrement Controller

This block is the front end of a small 16-bit processor. A microsequencer walks a fixed microprogram that handles the console start handshake, fetches one instruction word over an asynchronous read bus, and, when the source field selects register autoincrement, reads the source operand and bumps the source register. The block owns the program counter, eight general registers, a working register whose contents always drive the console lamps, a bus address register and an instruction register.

A bus read is started by loading the address register and raising a request. The request and the address stay put until the slave answers with its sync reply. Until then the sequencer sits in one microstate and changes nothing. When a byte operand comes from an odd address, the working register is shifted right one bit per microstep for eight microsteps. The high byte therefore lands in the low byte, and zeros fill in from the top. After the operand is aligned, the block raises a one-cycle ready pulse, turns off the run lamp and goes back to halt.

Instruction word fields used here: bit 15 is the byte flag (1 = byte), bits 11:9 are the source mode (2 = register autoincrement), and bits 8:6 select the source register.

Top module: `fetch_autoinc_ctl`

## Requirements
- R1: While halted, `runLamp` is 0 and `busReq` is 0. Raising `contSw` puts the PC on `lights` two clock edges later and holds it there while the switch stays high. `runLamp` turns on only after `contSw` has been released.
- R2: Each fetch reads from the current PC, and the PC then advances by 2. While the fetch is stalled, `lights` shows PC+2, and the next fetch uses the advanced address.
- R3: When `busReq` rises, `busAddr` holds steady and `busReq` stays high until `busSsyn` is seen, however long the slave takes. The request is then dropped, and the slave is expected to drop `busSsyn` after that.
- R4: Source mode 2 (bits 11:9 = 2) starts a second read at the value of the register selected by bits 8:6.
- R5: Autoincrement adds 1 to the source register for a byte instruction (bit 15 = 1) and 2 for a word instruction. The updated value is the address of the next mode-2 read through that register.
- R6: For a word instruction, and for a byte instruction at an even address, `lights` equals the fetched operand word while `opReady` is high.
- R7: For a byte instruction at an odd address, `lights` equals {8'h00, operand[15:8]} while `opReady` is high. This comes from eight single-bit right shifts with zero fill.
- R8: An instruction whose source mode is not 2 makes no second bus read, raises no `opReady`, and returns to halt.
- R9: `opReady` is high for exactly one cycle per mode-2 instruction, while `runLamp` is still on. `runLamp` goes off on the next edge.
- R10: Reset clears `runLamp`, `busReq`, `opReady` and `lights`. It sets the PC to RESET_PC (0x0200) and register i to i*0x1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low asynchronous reset |
| contSw | input | 1 | Console continue switch, high while pressed |
| busSsyn | input | 1 | Slave sync reply: read data valid |
| busRdata | input | 16 | Read data from the bus slave |
| busAddr | output | 16 | Bus address register |
| busReq | output | 1 | Read request, held until the reply arrives |
| lights | output | 16 | Console lamps showing the working register |
| runLamp | output | 1 | Run indicator |
| opReady | output | 1 | One-cycle pulse once the source operand is aligned |

## Verification
A wrong microstate or a misrouted strobe shows up at the ports within a few cycles. It can appear as a request address that is not the expected PC or register value, as the wrong value on the lamps during the console hold or during a fetch stall, or as a request that drops before the sync reply. Corrupted PC or register state is seen on the very next instruction, because its fetch or source read goes to the wrong address. Alignment faults appear on the lamps during the ready pulse, when they are compared against the operand the responder returned.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;

  localparam logic [2:0] MODE_AUTOINC = 3'd2;

  // 4-bit microcode control field
  typedef enum logic [3:0] {
    OP_NOP, OP_B_PC, OP_RUN_ON, OP_BA_PC_RD, OP_B_PC2, OP_PC_B,
    OP_LATCH_IR, OP_BA_REG_RD, OP_B_REG_INC, OP_REG_B,
    OP_LATCH_OPND, OP_SHIFT_R, OP_RUN_OFF
  } uOp_t;

  // microstate doubles as the 8-bit microcode store address
  typedef enum logic [7:0] {
    US_HALT      = 8'h00,
    US_CONT_LOAD = 8'h10, US_CONT_WAIT, US_CONT_RUN,
    US_F_ADDR    = 8'h20, US_F_INC, US_F_PC, US_F_LATCH, US_F_DISPATCH,
    US_S_ADDR    = 8'h30, US_S_INC, US_S_WB, US_S_LATCH,
    US_SHR0      = 8'h40, US_SHR1, US_SHR2, US_SHR3,
    US_SHR4, US_SHR5, US_SHR6, US_SHR7,
    US_S_END     = 8'h50, US_X_END
  } uState_t;

  typedef struct packed {
    logic bFromPc;
    logic bFromPc2;
    logic pcFromB;
    logic baFromPcRd;
    logic baFromRegRd;
    logic bFromRegInc;
    logic regFromB;
    logic latchInstr;
    logic latchOperand;
    logic shiftB;
    logic runOn;
    logic runOff;
  } dpStrobe_t;

endpackage

// File: rtl/ucode_seq.sv
module ucode_seq
  import fetch_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       contSw,
  input  logic       busSsyn,
  input  logic       irByte,
  input  logic [2:0] irMode,
  input  logic       operandOdd,
  output dpStrobe_t  strobe,
  output logic       opReady
);

  uState_t state, stateNext;
  uOp_t    uOp;

  // constant 256 x 4 microcode store; unlisted locations hold NOP
  function automatic uOp_t ucodeRom(input logic [7:0] loc);
    case (uState_t'(loc))
      US_CONT_LOAD:  return OP_B_PC;
      US_CONT_RUN:   return OP_RUN_ON;
      US_F_ADDR:     return OP_BA_PC_RD;
      US_F_INC:      return OP_B_PC2;
      US_F_PC:       return OP_PC_B;
      US_F_LATCH:    return OP_LATCH_IR;
      US_S_ADDR:     return OP_BA_REG_RD;
      US_S_INC:      return OP_B_REG_INC;
      US_S_WB:       return OP_REG_B;
      US_S_LATCH:    return OP_LATCH_OPND;
      US_SHR0, US_SHR1, US_SHR2, US_SHR3,
      US_SHR4, US_SHR5, US_SHR6, US_SHR7:
                     return OP_SHIFT_R;
      US_S_END, US_X_END:
                     return OP_RUN_OFF;
      default:       return OP_NOP;
    endcase
  endfunction

  assign uOp = ucodeRom(state);

  always_comb begin
    strobe = '0;
    case (uOp)
      OP_B_PC:       strobe.bFromPc      = 1'b1;
      OP_RUN_ON:     strobe.runOn        = 1'b1;
      OP_BA_PC_RD:   strobe.baFromPcRd   = 1'b1;
      OP_B_PC2:      strobe.bFromPc2     = 1'b1;
      OP_PC_B:       strobe.pcFromB      = 1'b1;
      OP_LATCH_IR:   strobe.latchInstr   = 1'b1;
      OP_BA_REG_RD:  strobe.baFromRegRd  = 1'b1;
      OP_B_REG_INC:  strobe.bFromRegInc  = 1'b1;
      OP_REG_B:      strobe.regFromB     = 1'b1;
      OP_LATCH_OPND: strobe.latchOperand = 1'b1;
      OP_SHIFT_R:    strobe.shiftB       = 1'b1;
      OP_RUN_OFF:    strobe.runOff       = 1'b1;
      default:       strobe = '0;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      US_HALT:       if (contSw) stateNext = US_CONT_LOAD;
      US_CONT_LOAD:  stateNext = US_CONT_WAIT;
      US_CONT_WAIT:  if (!contSw) stateNext = US_CONT_RUN;
      US_CONT_RUN:   stateNext = US_F_ADDR;
      US_F_ADDR:     stateNext = US_F_INC;
      US_F_INC:      stateNext = US_F_PC;
      US_F_PC:       if (busSsyn) stateNext = US_F_LATCH;
      US_F_LATCH:    stateNext = US_F_DISPATCH;
      US_F_DISPATCH: stateNext = (irMode == MODE_AUTOINC) ? US_S_ADDR : US_X_END;
      US_S_ADDR:     stateNext = US_S_INC;
      US_S_INC:      stateNext = US_S_WB;
      US_S_WB:       if (busSsyn) stateNext = US_S_LATCH;
      US_S_LATCH:    stateNext = (irByte && operandOdd) ? US_SHR0 : US_S_END;
      US_SHR0, US_SHR1, US_SHR2, US_SHR3,
      US_SHR4, US_SHR5, US_SHR6:
                     stateNext = uState_t'(state + 8'd1);
      US_SHR7:       stateNext = US_S_END;
      default:       stateNext = US_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= US_HALT;
    else       state <= stateNext;
  end

  assign opReady = (state == US_S_END);

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    opReady |=> !opReady);                                        // R9
  AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == US_CONT_WAIT && contSw) |=> !strobe.runOn);         // R1
  AST_NOREAD_OTHER: assert property (@(posedge clk) disable iff (!rstN)
    (state == US_F_DISPATCH && irMode != MODE_AUTOINC) |=> !strobe.baFromRegRd); // R8

endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
  import fetch_ctl_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          NREG     = 8,
  parameter logic [15:0] RESET_PC = 16'h0200,
  parameter int          REG_STEP = 16'h1000
)(
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [W-1:0]  busRdata,
  input  logic          busSsyn,
  output logic [W-1:0]  busAddr,
  output logic          busReq,
  output logic [W-1:0]  lights,
  output logic          runLamp,
  output logic          irByte,
  output logic [2:0]    irMode,
  output logic          operandOdd
);

  localparam int SEL_W     = $clog2(NREG);
  localparam int BYTE_BIT  = 15;
  localparam int MODE_LSB  = 9;
  localparam int REG_LSB   = 6;

  logic [W-1:0]     pc, bReg, baReg, irReg;
  logic [W-1:0]     regs [NREG];
  logic [SEL_W-1:0] srcSel;
  logic [W-1:0]     incAmt;

  assign srcSel = irReg[REG_LSB +: SEL_W];
  assign incAmt = irReg[BYTE_BIT] ? W'(1) : W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= W'(RESET_PC);
      bReg    <= '0;
      baReg   <= '0;
      irReg   <= '0;
      busReq  <= 1'b0;
      runLamp <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= W'(REG_STEP * i);
    end else begin
      if (strobe.bFromPc)  bReg <= pc;
      if (strobe.bFromPc2) bReg <= pc + W'(2);
      if (strobe.pcFromB)  pc   <= bReg;
      if (strobe.baFromPcRd) begin
        baReg  <= pc;
        busReq <= 1'b1;
      end
      if (strobe.baFromRegRd) begin
        baReg  <= regs[srcSel];
        busReq <= 1'b1;
      end
      if (strobe.bFromRegInc) bReg <= regs[srcSel] + incAmt;
      if (strobe.regFromB)    regs[srcSel] <= bReg;
      if (strobe.latchInstr) begin
        bReg   <= busRdata;
        irReg  <= busRdata;
        busReq <= 1'b0;
      end
      if (strobe.latchOperand) begin
        bReg   <= busRdata;
        busReq <= 1'b0;
      end
      if (strobe.shiftB) bReg    <= {1'b0, bReg[W-1:1]};
      if (strobe.runOn)  runLamp <= 1'b1;
      if (strobe.runOff) runLamp <= 1'b0;
    end
  end

  assign busAddr    = baReg;
  assign lights     = bReg;
  assign irByte     = irReg[BYTE_BIT];
  assign irMode     = irReg[MODE_LSB +: 3];
  assign operandOdd = baReg[0];

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busSsyn) |=> (busReq && $stable(busAddr)));       // R3
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !runLamp |-> !busReq);                                        // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pcFromB |=> (pc == $past(busAddr) + W'(2)));           // R2
  AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftB |=> !lights[W-1]);                              // R7

endmodule

// File: rtl/fetch_autoinc_ctl.sv
module fetch_autoinc_ctl
  import fetch_ctl_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          NREG     = 8,
  parameter logic [15:0] RESET_PC = 16'h0200,
  parameter int          REG_STEP = 16'h1000
)(
  input  logic         clk,
  input  logic         rstN,
  input  logic         contSw,
  input  logic         busSsyn,
  input  logic [W-1:0] busRdata,
  output logic [W-1:0] busAddr,
  output logic         busReq,
  output logic [W-1:0] lights,
  output logic         runLamp,
  output logic         opReady
);

  dpStrobe_t  strobe;
  logic       irByte;
  logic [2:0] irMode;
  logic       operandOdd;

  ucode_seq uSeq (
    .clk(clk), .rstN(rstN), .contSw(contSw), .busSsyn(busSsyn),
    .irByte(irByte), .irMode(irMode), .operandOdd(operandOdd),
    .strobe(strobe), .opReady(opReady)
  );

  fetch_datapath #(.W(W), .NREG(NREG), .RESET_PC(RESET_PC), .REG_STEP(REG_STEP)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busRdata(busRdata),
    .busSsyn(busSsyn), .busAddr(busAddr), .busReq(busReq),
    .lights(lights), .runLamp(runLamp), .irByte(irByte),
    .irMode(irMode), .operandOdd(operandOdd)
  );

endmodule

// File: tb/tb_fetch_autoinc_ctl.sv
module tb_fetch_autoinc_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        contSw = 1'b0;
  logic        busSsyn = 1'b0;
  logic [15:0] busRdata = '0;
  logic [15:0] busAddr, lights;
  logic        busReq, runLamp, opReady;

  int          checks = 0;
  int          failures = 0;
  bit          allDone = 0;
  int          reqCount = 0;
  int          stallLen = -1;
  logic [15:0] curInstr = '0;
  logic [15:0] expFetch = 16'h0200;
  logic [15:0] expSrc = '0;
  logic [15:0] srcWord = '0;
  logic [15:0] pcExp = 16'h0200;
  logic [15:0] regExp [8];

  always #4 clk = ~clk;

  fetch_autoinc_ctl dut (
    .clk(clk), .rstN(rstN), .contSw(contSw), .busSsyn(busSsyn),
    .busRdata(busRdata), .busAddr(busAddr), .busReq(busReq),
    .lights(lights), .runLamp(runLamp), .opReady(opReady)
  );

  function automatic logic [15:0] opData(input logic [15:0] a);
    return (a * 16'h3B1D) ^ 16'hC6A5;
  endfunction

  function automatic logic [15:0] expLights(input bit byteF, input logic [15:0] a,
                                            input logic [15:0] w);
    return (byteF && a[0]) ? {8'h00, w[15:8]} : w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus slave: random reply delay, holds sync until the request drops
  initial begin
    forever begin
      @(negedge clk);
      if (busReq && !busSsyn) begin
        automatic logic [15:0] addr = busAddr;
        automatic int dly = (stallLen >= 0) ? stallLen : int'($urandom_range(0, 4));
        reqCount++;
        if (reqCount == 1) check(addr == expFetch, "R2 fetch address", addr, expFetch);
        else               check(addr == expSrc, "R4/R5 source address", addr, expSrc);
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          check(busReq && busAddr == addr, "R3 request held during stall", busAddr, addr);
        end
        if (reqCount == 1 && dly >= 2)
          check(lights == addr + 16'd2, "R2 lights PC+2 in stall", lights, addr + 16'd2);
        if (reqCount == 1) busRdata = curInstr;
        else begin
          srcWord  = opData(addr);
          busRdata = srcWord;
        end
        busSsyn = 1'b1;
        do @(negedge clk); while (busReq);
        busSsyn = 1'b0;
      end
    end
  end

  task automatic runInstr(input bit byteF, input logic [2:0] mode, input int rs);
    int hold;
    int ready = 0;
    logic [15:0] cap = '0;
    logic [15:0] want;
    logic [15:0] srcAddr = regExp[rs];
    curInstr = {byteF, 3'b000, mode, 3'(rs), 6'o00};
    expFetch = pcExp;
    expSrc   = srcAddr;
    reqCount = 0;
    hold = 2 + int'($urandom_range(0, 2));
    @(negedge clk); contSw = 1'b1;
    repeat (2) @(negedge clk);
    check(lights == pcExp, "R1 lights show PC while held", lights, pcExp);
    check(!runLamp && !busReq, "R1 no run while switch held", {runLamp, busReq}, 0);
    repeat (hold - 2) @(negedge clk);
    contSw = 1'b0;
    while (!runLamp) @(negedge clk);
    while (runLamp) begin
      if (opReady) begin ready++; cap = lights; end
      @(negedge clk);
    end
    if (mode == 3'd2) begin
      want = expLights(byteF, srcAddr, srcWord);
      check(ready == 1, "R9 single ready pulse", 16'(ready), 1);
      check(reqCount == 2, "R4 source read issued", 16'(reqCount), 2);
      if (byteF && srcAddr[0]) check(cap == want, "R7 odd byte aligned", cap, want);
      else                     check(cap == want, "R6 operand on lights", cap, want);
      regExp[rs] = srcAddr + (byteF ? 16'd1 : 16'd2);
    end else begin
      check(ready == 0, "R8 no ready for other mode", 16'(ready), 0);
      check(reqCount == 1, "R8 no source read", 16'(reqCount), 1);
    end
    check(!runLamp && !opReady, "R9 halted after instruction", {runLamp, opReady}, 0);
    pcExp = pcExp + 16'd2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!allDone) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20917));
    for (int i = 0; i < 8; i++) regExp[i] = 16'(i * 16'h1000);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!runLamp && !busReq && !opReady, "R10 reset outputs idle",
          {runLamp, busReq, opReady}, 0);
    check(lights == 16'h0000, "R10 reset lights", lights, 0);
    // R10: the first console press shows RESET_PC; checked inside runInstr
    runInstr(1'b1, 3'd2, 1);     // R6 byte even at 0x1000
    runInstr(1'b1, 3'd2, 1);     // R7 byte odd at 0x1001
    runInstr(1'b0, 3'd2, 1);     // R5 word after byte increments, at 0x1002
    stallLen = 20;
    runInstr(1'b0, 3'd2, 3);     // R3 long stall on both reads
    runInstr(1'b1, 3'd2, 3);
    stallLen = 0;
    runInstr(1'b1, 3'd2, 3);     // R7 odd byte with zero-delay reply
    stallLen = -1;
    runInstr(1'b0, 3'd0, 2);     // R8 register mode: no source read
    runInstr(1'b1, 3'd5, 4);     // R8 another non-autoinc mode
    for (int n = 0; n < 24; n++) begin
      automatic bit byteF = 1'($urandom_range(0, 1));
      automatic logic [2:0] mode = ($urandom_range(0, 3) == 0) ? 3'(($urandom_range(3, 7))) : 3'd2;
      runInstr(byteF, mode, int'($urandom_range(0, 7)));
    end
    allDone = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule